// File: doc/BRIEF.md
# I2C Target Read Engine with Persistent Address Counter

This block is the read side of a serial memory target on a two-wire bus. It watches the clock and data lines with the system clock and recognises START, repeated START and STOP conditions. It accepts an address byte whose top four bits are the fixed type code `1010` and whose next three bits match a strap input. It answers reads from an internal byte array of `2**ADDR_W` bytes. The default build uses `ADDR_W = 11`. A full 16 KiB build sets `ADDR_W = 14`, which gives a 14-bit word address.

The read position is held in a counter that survives between transactions. The counter always holds the address of the last byte sent, plus one. A master moves the counter by sending a write-type header with two word-address bytes and then issuing a repeated START. After that, a read-type header returns bytes from the new position. An acknowledge from the master after a byte asks for the next byte. A not-acknowledge ends the stream.

A test loader port writes the array one byte per clock. It has a valid strobe and no ready: every strobe is accepted, so it never applies back-pressure. Programming the array from the bus is not part of this block.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: After reset, `sda_oe` is 0 and the read counter is 0, so the first read returns the byte at address 0.
- R2: An address byte is accepted only if bits [7:4] are `1010` and bits [3:1] equal `strap_i`; bit 0 is the direction, with 1 meaning read. An accepted byte is acknowledged by driving SDA low in the 9th clock. A byte that does not match gets no acknowledge, and the block then ignores the bus until the next START.
- R3: A read header returns the byte at the counter, sent MSB first. After each byte is loaded for sending, the counter holds that byte's address plus 1.
- R4: A write header followed by two word-address bytes (high byte first) is acknowledged byte by byte. A repeated START after those bytes loads the counter with the low `ADDR_W` bits of the 16-bit word. Bits above `ADDR_W` are ignored.
- R5: If the word-address bytes are followed by a STOP instead of a repeated START, the counter keeps its previous value.
- R6: When the master acknowledges a byte, the block sends the next sequential byte. When the master does not acknowledge, the block releases SDA and goes idle.
- R7: The counter wraps from `2**ADDR_W - 1` to 0, both between transactions and inside a sequential stream, with no break in the stream.
- R8: `sda_oe` changes only while SCL is low.
- R9: A START or STOP at any point releases SDA and returns the block to address reception without changing the counter. A START before the low word-address byte is complete loads nothing.
- R10: When `bk_valid` is high at a clock edge, `bk_data` is written at `bk_addr`. There is no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run well above the bus bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (the wired level) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| strap_i | input | 3 | Address select straps compared with bits [3:1] of the address byte |
| bk_valid | input | 1 | Loader write strobe |
| bk_addr | input | ADDR_W | Loader byte address |
| bk_data | input | 8 | Loader byte value |

## Verification
Each bus line passes through two synchronizer stages and one edge register. The block therefore sees an SCL edge, START or STOP about three system clocks after the pin changes, and `sda_oe` moves on the clock after that. The bench master holds every SCL phase for six clocks. It changes SDA only a full phase after SCL falls and samples SDA a full phase after SCL rises, so each target response has settled before it is read. A loader write is visible to the next header, because the array is read without a register and is not looked at again until a whole bus byte later.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_WHI,
    S_WHI_ACK,
    S_WLO,
    S_WLO_ACK,
    S_TX,
    S_TX_ACK
  } rd_state_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sh[SYNC_STAGES-1];
      sda_q  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) arr[wr_addr] <= wr_data;
  end

  assign rd_data = arr[rd_addr];
endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [2:0]        strap_i,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              pend_vld,
  output logic              in_idle,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  rd_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx, tx, hi;
  logic              rw, go_on;
  logic [ADDR_W-1:0] pend_addr;
  logic [15:0]       word_addr;
  logic              dev_hit;

  assign word_addr = {hi, rx};
  assign dev_hit   = (rx[7:4] == DEV_TYPE) && (rx[3:1] == strap_i);
  assign in_idle   = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '0;
      hi        <= '0;
      rw        <= 1'b0;
      go_on     <= 1'b0;
      ptr       <= '0;
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      sda_oe    <= 1'b0;
    end else if (stop_evt) begin
      st       <= S_IDLE;
      sda_oe   <= 1'b0;
      pend_vld <= 1'b0;
    end else if (start_evt) begin
      st     <= S_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
      if (pend_vld) begin
        ptr      <= pend_addr;
        pend_vld <= 1'b0;
      end
    end else begin
      unique case (st)
        S_DEV, S_WHI, S_WLO: begin
          if (scl_rise && cnt != LAST_RX) begin
            rx  <= {rx[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST_RX) begin
            cnt <= '0;
            if (st == S_DEV) begin
              if (dev_hit) begin
                rw     <= rx[0];
                sda_oe <= 1'b1;
                st     <= S_DEV_ACK;
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_WHI) begin
              hi     <= rx;
              sda_oe <= 1'b1;
              st     <= S_WHI_ACK;
            end else begin
              pend_addr <= word_addr[ADDR_W-1:0];
              pend_vld  <= 1'b1;
              sda_oe    <= 1'b1;
              st        <= S_WLO_ACK;
            end
          end
        end
        S_DEV_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              tx     <= rd_data;
              ptr    <= ptr + 1'b1;
              sda_oe <= ~rd_data[BYTE_W-1];
              cnt    <= '0;
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WHI;
            end
          end
        end
        S_WHI_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_WLO;
          end
        end
        S_WLO_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_IDLE;
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt == LAST_TX) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= S_TX_ACK;
            end else begin
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_W-2];
              cnt    <= cnt + 1'b1;
            end
          end
        end
        S_TX_ACK: begin
          if (scl_rise) begin
            go_on <= ~sda_s;
          end else if (scl_fall) begin
            if (go_on) begin
              tx     <= rd_data;
              ptr    <= ptr + 1'b1;
              sda_oe <= ~rd_data[BYTE_W-1];
              cnt    <= '0;
              st     <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_eeprom_reader.sv
module i2c_eeprom_reader #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  input  logic              bk_valid,
  input  logic [ADDR_W-1:0] bk_addr,
  input  logic [7:0]        bk_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] rd_data;
  logic pend_vld, in_idle;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_rd_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .wr_en(bk_valid), .wr_addr(bk_addr), .wr_data(bk_data),
    .rd_addr(ptr), .rd_data(rd_data)
  );

  i2c_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .strap_i(strap_i), .rd_data(rd_data), .ptr(ptr), .pend_vld(pend_vld),
    .in_idle(in_idle), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2c_eeprom_reader_chk.sv
module i2c_eeprom_reader_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              sda_oe,
  input logic [ADDR_W-1:0] ptr,
  input logic              pend_vld,
  input logic              in_idle
);
  a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  a_r9_stop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> $stable(ptr));

  a_r5_stop_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !pend_vld);

  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  a_r2_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !start_evt) |=> in_idle);
endmodule

bind i2c_eeprom_reader i2c_eeprom_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .ptr(ptr), .pend_vld(pend_vld),
  .in_idle(in_idle)
);

// File: tb/test_i2c_eeprom_reader.sv
`timescale 1ns/1ps
module test_i2c_eeprom_reader;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic bk_valid = 1'b0;
  logic [AW-1:0] bk_addr = '0;
  logic [7:0] bk_data = '0;

  int tests = 0, fails = 0, r8_viol = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [DEPTH];
  int exp_ptr = 0;
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_eeprom_reader #(.ADDR_W(AW)) i_i2c_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(STRAP), .bk_valid(bk_valid), .bk_addr(bk_addr), .bk_data(bk_data)
  );

  // R8 monitor: the target drive may not move while the master holds SCL high
  always @(negedge clk) begin
    if (rst_n && scl_m && sda_oe != prev_oe) r8_viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq(); sda_m = 1'b0; waitq(); scl_m = 1'b0; waitq();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; waitq(); scl_m = 1'b1; waitq(); sda_m = 1'b1; waitq();
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; waitq(); scl_m = 1'b1; waitq(); waitq(); scl_m = 1'b0; waitq();
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq(); b = sda_line; waitq(); scl_m = 1'b0; waitq();
  endtask

  task automatic m_wbyte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
    m_rbit(b);
    acked = ~b;
  endtask

  task automatic m_rbyte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b);
      v[i] = b;
    end
    m_wbit(~ack);
  endtask

  task automatic dev(input logic rw, input string req);
    logic ok;
    m_start();
    m_wbyte({4'b1010, STRAP, rw}, ok);
    chk(req, ok, 1);
  endtask

  task automatic read_seq(input int n, input string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      m_rbyte(v, i < n - 1);
      chk(req, v, exp_mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % DEPTH;
    end
    chk("R6", sda_oe, 0);
  endtask

  task automatic cur_read(input int n, input string req);
    dev(1'b1, "R2");
    read_seq(n, req);
    m_stop();
  endtask

  task automatic set_addr(input logic [15:0] a, input string req);
    logic ok;
    dev(1'b0, "R2");
    m_wbyte(a[15:8], ok); chk(req, ok, 1);
    m_wbyte(a[7:0], ok);  chk(req, ok, 1);
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string req);
    set_addr(a, "R4");
    dev(1'b1, "R4");
    exp_ptr = int'(a) % DEPTH;
    read_seq(n, req);
    m_stop();
  endtask

  task automatic bk_write(input int a, input logic [7:0] d);
    bk_valid = 1'b1; bk_addr = AW'(a); bk_data = d;
    @(negedge clk);
    bk_valid = 1'b0;
    exp_mem[a] = d;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ok;
    void'($urandom(32'h1c2e_0451));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", sda_oe, 0);
    for (int a = 0; a < DEPTH; a++) bk_write(a, 8'($urandom));
    // R1, R3: first read comes from address 0
    cur_read(2, "R1");
    cur_read(1, "R3");
    // R2: wrong straps get no acknowledge, and bytes before a new START are ignored
    m_start();
    m_wbyte({4'b1010, ~STRAP, 1'b1}, ok); chk("R2", ok, 0);
    m_wbyte({4'b1010, STRAP, 1'b1}, ok);  chk("R2", ok, 0);
    m_stop();
    m_start();
    m_wbyte({4'b0110, STRAP, 1'b1}, ok);  chk("R2", ok, 0);
    m_stop();
    cur_read(1, "R2");
    // R4, R6: random then sequential
    rand_read(16'h0123, 1, "R4");
    rand_read(16'h0400, 5, "R6");
    cur_read(2, "R3");
    // R4: bits above ADDR_W ignored
    rand_read(16'hF9A5, 2, "R4");
    // R5: word address closed by STOP leaves the counter alone
    set_addr(16'h0077, "R5");
    m_stop();
    cur_read(1, "R5");
    // R9: START before low address byte loads nothing
    dev(1'b0, "R9");
    m_wbyte(8'h02, ok); chk("R9", ok, 1);
    dev(1'b1, "R9");
    read_seq(1, "R9");
    m_stop();
    // R9: STOP inside an address byte
    m_start();
    for (int i = 0; i < 4; i++) m_wbit(1'b1);
    m_stop();
    chk("R9", sda_oe, 0);
    cur_read(1, "R9");
    // R7: wrap inside a stream and between transactions
    rand_read(16'(DEPTH - 2), 4, "R7");
    rand_read(16'(DEPTH - 1), 1, "R7");
    cur_read(1, "R7");
    // R10: loader overwrite is read back
    bk_write(300, 8'h5A);
    bk_write(301, 8'hC3);
    rand_read(16'd300, 2, "R10");
    // random mix
    for (int it = 0; it < 24; it++) begin
      int n = 1 + int'($urandom % 4);
      if ($urandom % 2 == 0) cur_read(n, "R3");
      else rand_read(16'($urandom), n, "R6");
    end
    chk("R8", r8_viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule